// File: doc/BRIEF.md
# Preemptive Interrupt Priority Stack Controller

This block tracks the priority level the processor is currently running at and decides when a pending interrupt may cut in. Each of a set of request lines carries its own priority. When the best pending priority is strictly higher than the running level, the block raises one request line to the processor and captures the number of the winning source.

When the processor acknowledges, the running level is saved on a small internal stack and the winner's priority becomes the new running level. When the handler finishes, it issues an end-of-interrupt pulse. That pulse pops the stack, which puts the interrupted level back.

The stack has one entry fewer than there are nonzero levels. If it is pushed while full, the oldest saved level is dropped. If it is popped while empty, it returns zero, so the lowest level always comes back. The stack is internal and cannot be read or written from outside.

Top module: `prio_preempt_ctrl`

## Requirements
- R1: After reset the running level is 0, the processor request is low and the captured vector is 0.
- R2: The processor request rises one clock after some enabled source has a priority strictly above the running level. A source at or below the running level never raises it, so a source at priority 0 can never win.
- R3: The source with the highest priority wins. Among sources tied at the highest priority, the lowest-numbered one wins.
- R4: The vector output is loaded with the winner's number on the clock where the request rises. It holds that value while the request stays high, even if a better source appears meanwhile.
- R5: An acknowledge while the request is high pushes the running level and loads the captured priority as the new running level, on the same clock edge. The request is low in the following cycle and is evaluated again against the new level one clock later.
- R6: An acknowledge while the request is low changes neither the running level nor the stack.
- R7: An end-of-interrupt pulse pops the stack into the running level, one clock after the pulse, and holds the request low for that cycle. Nested levels come back in reverse order.
- R8: After a pop, no source at or below the restored level raises the request. There is no re-selection of the interrupted source.
- R9: The stack holds 2^PRIO_W-2 levels (14 by default). A push while full drops the oldest entry, so after 15 nested acknowledges the pops return the newest 14 levels.
- R10: A pop from an empty stack loads 0 into the running level.
- R11: When an accepted acknowledge and an end-of-interrupt arrive in the same cycle, the acknowledge takes effect on that clock edge. The pop takes effect on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | NUM_SRC | Pending flag per source |
| irq_prio_i | input | NUM_SRC*PRIO_W | Packed priority per source; source i uses bits [i*PRIO_W +: PRIO_W] |
| ack_i | input | 1 | Processor acknowledge pulse |
| eoi_i | input | 1 | End-of-interrupt pulse |
| cpu_req_o | output | 1 | Interrupt request to the processor |
| vec_o | output | IDX_W | Number of the source captured at the request's rise |
| cur_prio_o | output | PRIO_W | Running priority level |

## Verification
All three outputs are registered. A change on a source line shows on the request and the vector one clock later. An acknowledge, or an end-of-interrupt that is not blocked by an acknowledge, moves the running level one clock later. An end-of-interrupt that collides with an acknowledge lands two clocks later.

The driver stamps every expected output triple with the cycle number in which it is due. It drives inputs on falling edges. The monitor compares each entry on the falling edge of exactly that cycle, and it reports any entry it has passed over as a failure.

// File: rtl/prio_preempt_pkg.sv
package prio_preempt_pkg;

   // Index width that stays at least one bit for tiny source counts.
   function automatic int unsigned idx_width(int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

   // Saved-level capacity: every nonzero level except the topmost.
   function automatic int unsigned stack_slots(int unsigned prio_w);
      return (1 << prio_w) - 2;
   endfunction

endpackage

// File: rtl/prio_arbiter.sv
module prio_arbiter #(
   parameter int unsigned NUM_SRC = 8,
   parameter int unsigned PRIO_W  = 4,
   parameter int unsigned IDX_W   = 3
) (
   input  logic [NUM_SRC-1:0]        req_i,
   input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
   output logic                      any_o,
   output logic [IDX_W-1:0]          win_idx_o,
   output logic [PRIO_W-1:0]         win_prio_o
);

   if (NUM_SRC < 1) begin : g_bad_src
      $error("prio_arbiter: NUM_SRC must be at least 1");
   end
   if ((1 << IDX_W) < NUM_SRC) begin : g_bad_idx
      $error("prio_arbiter: IDX_W too narrow for NUM_SRC");
   end

   // Strict compare keeps the earliest index on a tie.
   always_comb begin
      any_o      = 1'b0;
      win_idx_o  = '0;
      win_prio_o = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (req_i[i] && (!any_o || (prio_i[i*PRIO_W +: PRIO_W] > win_prio_o))) begin
            any_o      = 1'b1;
            win_idx_o  = IDX_W'(i);
            win_prio_o = prio_i[i*PRIO_W +: PRIO_W];
         end
      end
   end

endmodule

// File: rtl/prio_lifo.sv
module prio_lifo #(
   parameter int unsigned DEPTH = 14,
   parameter int unsigned W     = 4
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         push_i,
   input  logic         pop_i,
   input  logic [W-1:0] data_i,
   output logic [W-1:0] top_o
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("prio_lifo: DEPTH must be at least 1");
   end

   // Shift-register stack: slot 0 is the top. A push shifts everything
   // down and the deepest slot falls off; a pop shifts up and fills zero.
   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [W-1:0] val_q;
      logic [W-1:0] from_up;
      logic [W-1:0] from_down;

      if (g == 0) begin : g_head
         assign from_up = data_i;
      end else begin : g_body
         assign from_up = g_slot[g-1].val_q;
      end

      if (g == DEPTH - 1) begin : g_tail
         assign from_down = '0;
      end else begin : g_inner
         assign from_down = g_slot[g+1].val_q;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            val_q <= '0;
         end else if (push_i) begin
            val_q <= from_up;
         end else if (pop_i) begin
            val_q <= from_down;
         end
      end
   end

   assign top_o = g_slot[0].val_q;

   assert_push_lands_on_top_R9: assert property (
      @(posedge clk_i) disable iff (!rst_ni)
      push_i |=> (top_o == $past(data_i))
   ) else $error("push did not land on top of stack");

endmodule

// File: rtl/prio_preempt_ctrl.sv
module prio_preempt_ctrl
   import prio_preempt_pkg::*;
#(
   parameter int unsigned NUM_SRC     = 8,
   parameter int unsigned PRIO_W      = 4,
   parameter int unsigned STACK_DEPTH = stack_slots(PRIO_W),
   localparam int unsigned IDX_W      = idx_width(NUM_SRC)
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic [NUM_SRC-1:0]        irq_req_i,
   input  logic [NUM_SRC*PRIO_W-1:0] irq_prio_i,
   input  logic                      ack_i,
   input  logic                      eoi_i,
   output logic                      cpu_req_o,
   output logic [IDX_W-1:0]          vec_o,
   output logic [PRIO_W-1:0]         cur_prio_o
);

   if (PRIO_W < 2 || PRIO_W > 8) begin : g_bad_prio
      $error("prio_preempt_ctrl: PRIO_W must be 2..8");
   end
   if (STACK_DEPTH < 1) begin : g_bad_stack
      $error("prio_preempt_ctrl: STACK_DEPTH must be at least 1");
   end

   logic              any_w;
   logic [IDX_W-1:0]  win_idx_w;
   logic [PRIO_W-1:0] win_prio_w;
   logic [PRIO_W-1:0] stack_top_w;

   logic              req_q;
   logic [IDX_W-1:0]  vec_q;
   logic [PRIO_W-1:0] vprio_q;
   logic [PRIO_W-1:0] cur_q;
   logic              eoi_pend_q;

   logic hit_w, ack_take_w, eoi_want_w, pop_w;

   prio_arbiter #(
      .NUM_SRC (NUM_SRC),
      .PRIO_W  (PRIO_W),
      .IDX_W   (IDX_W)
   ) arb_i (
      .req_i      (irq_req_i),
      .prio_i     (irq_prio_i),
      .any_o      (any_w),
      .win_idx_o  (win_idx_w),
      .win_prio_o (win_prio_w)
   );

   assign hit_w      = any_w && (win_prio_w > cur_q);
   assign ack_take_w = ack_i && req_q;
   assign eoi_want_w = eoi_i || eoi_pend_q;
   assign pop_w      = eoi_want_w && !ack_take_w;

   prio_lifo #(
      .DEPTH (STACK_DEPTH),
      .W     (PRIO_W)
   ) lifo_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .push_i (ack_take_w),
      .pop_i  (pop_w),
      .data_i (cur_q),
      .top_o  (stack_top_w)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         req_q      <= 1'b0;
         vec_q      <= '0;
         vprio_q    <= '0;
         cur_q      <= '0;
         eoi_pend_q <= 1'b0;
      end else begin
         eoi_pend_q <= eoi_want_w && ack_take_w;
         if (ack_take_w) begin
            cur_q <= vprio_q;
            req_q <= 1'b0;
         end else if (pop_w) begin
            cur_q <= stack_top_w;
            req_q <= 1'b0;
         end else begin
            req_q <= hit_w;
            if (!req_q && hit_w) begin
               vec_q   <= win_idx_w;
               vprio_q <= win_prio_w;
            end
         end
      end
   end

   assign cpu_req_o  = req_q;
   assign vec_o      = vec_q;
   assign cur_prio_o = cur_q;

   assert_req_above_level_R2: assert property (
      @(posedge clk_i) disable iff (!rst_ni)
      req_q |-> (vprio_q > cur_q)
   ) else $error("request high without a higher captured priority");

   assert_vector_held_R4: assert property (
      @(posedge clk_i) disable iff (!rst_ni)
      (req_q && $past(req_q)) |-> $stable(vec_q)
   ) else $error("vector changed while request held");

   assert_ack_loads_level_R5: assert property (
      @(posedge clk_i) disable iff (!rst_ni)
      (ack_i && req_q) |=> (!req_q && (cur_q == $past(vprio_q)))
   ) else $error("acknowledge did not adopt captured priority");

   assert_idle_ack_ignored_R6: assert property (
      @(posedge clk_i) disable iff (!rst_ni)
      (ack_i && !req_q && !eoi_want_w) |=> $stable(cur_q)
   ) else $error("acknowledge without request moved the level");

   assert_eoi_deferred_R11: assert property (
      @(posedge clk_i) disable iff (!rst_ni)
      (ack_take_w && eoi_want_w) |=> ##1 (cur_q == $past(cur_q, 2))
   ) else $error("colliding end-of-interrupt did not restore level");

endmodule

// File: tb/prio_preempt_ctrl_tb_top.sv
module prio_preempt_ctrl_tb_top;

   localparam int NSRC = 8;
   localparam int PW   = 4;
   localparam int IW   = 3;

   typedef struct {
      int          due;
      logic        req;
      logic [IW-1:0] vec;
      logic [PW-1:0] cur;
      string       tag;
   } exp_t;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [NSRC-1:0]    irq = '0;
   logic [NSRC*PW-1:0] prio = '0;
   logic               ack = 1'b0;
   logic               eoi = 1'b0;
   logic               cpu_req;
   logic [IW-1:0]      vec;
   logic [PW-1:0]      cur;

   int   cyc = 0;
   int   checks = 0;
   int   failures = 0;
   bit   done = 1'b0;
   exp_t sb_q[$];
   exp_t mon_item;

   always #2.5 clk = ~clk;

   always @(posedge clk) cyc = cyc + 1;

   prio_preempt_ctrl #(
      .NUM_SRC (NSRC),
      .PRIO_W  (PW)
   ) dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .irq_req_i  (irq),
      .irq_prio_i (prio),
      .ack_i      (ack),
      .eoi_i      (eoi),
      .cpu_req_o  (cpu_req),
      .vec_o      (vec),
      .cur_prio_o (cur)
   );

   // Monitor: compare each expected item on the falling edge it is due.
   always @(negedge clk) begin
      while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
         mon_item = sb_q.pop_front();
         checks++;
         if (mon_item.due != cyc || cpu_req !== mon_item.req ||
             vec !== mon_item.vec || cur !== mon_item.cur) begin
            failures++;
            $display("FAIL %s cyc=%0d due=%0d: actual req=%0b vec=%0d cur=%0d expected req=%0b vec=%0d cur=%0d",
                     mon_item.tag, cyc, mon_item.due, cpu_req, vec, cur,
                     mon_item.req, mon_item.vec, mon_item.cur);
         end
      end
   end

   // Driver helper: queue the result due after the next clock edge, then wait.
   task automatic exp_next(input logic r, input int v, input int c, input string t);
      exp_t e;
      e.due = cyc + 1;
      e.req = r;
      e.vec = IW'(v);
      e.cur = PW'(c);
      e.tag = t;
      sb_q.push_back(e);
      @(negedge clk);
   endtask

   task automatic set_src(input int i, input int p);
      irq[i] = 1'b1;
      prio[i*PW +: PW] = PW'(p);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired at cyc=%0d", cyc);
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (cpu_req !== 1'b0 || vec !== '0 || cur !== '0) begin
         failures++;
         $display("FAIL R1 reset: actual req=%0b vec=%0d cur=%0d expected req=0 vec=0 cur=0",
                  cpu_req, vec, cur);
      end

      set_src(2, 0);
      exp_next(0, 0, 0, "R2 priority 0 never preempts");
      set_src(5, 5); set_src(3, 5);
      exp_next(1, 3, 0, "R3 tie goes to lowest index");
      set_src(6, 9);
      exp_next(1, 3, 0, "R4 vector held while request high");
      ack = 1'b1;
      exp_next(0, 3, 5, "R5 acknowledge adopts level");
      ack = 1'b0;
      exp_next(1, 6, 5, "R3 R4 higher priority wins new assertion");
      ack = 1'b1;
      exp_next(0, 6, 9, "R5 nested acknowledge");
      ack = 1'b0;
      irq[6] = 1'b0;
      exp_next(0, 6, 9, "R2 at or below level no request");
      eoi = 1'b1;
      exp_next(0, 6, 5, "R7 pop restores level");
      eoi = 1'b0;
      ack = 1'b1;
      exp_next(0, 6, 5, "R6 R8 idle acknowledge, equal level ignored");
      ack = 1'b0;
      eoi = 1'b1;
      exp_next(0, 6, 0, "R7 second pop, stack untouched by idle ack");
      eoi = 1'b0;
      exp_next(1, 3, 0, "R2 request after restore");
      irq = '0;
      ack = 1'b1; eoi = 1'b1;
      exp_next(0, 3, 5, "R11 acknowledge first");
      ack = 1'b0; eoi = 1'b0;
      exp_next(0, 3, 0, "R11 pop one cycle later");
      eoi = 1'b1;
      exp_next(0, 3, 0, "R10 pop of empty stack");
      eoi = 1'b0;

      for (int p = 1; p <= 15; p++) begin
         set_src(0, p);
         exp_next(1, 0, p - 1, "R9 fill request");
         ack = 1'b1;
         exp_next(0, 0, p, "R9 fill acknowledge");
         ack = 1'b0;
      end
      irq = '0;
      eoi = 1'b1;
      for (int k = 14; k >= 1; k--) begin
         exp_next(0, 0, k, "R9 unwind");
      end
      exp_next(0, 0, 0, "R9 R10 oldest dropped, zero regenerated");
      exp_next(0, 0, 0, "R10 further empty pop");
      eoi = 1'b0;

      repeat (3) @(negedge clk);
      if (sb_q.size() != 0) begin
         failures++;
         $display("FAIL scoreboard: actual pending=%0d expected pending=0", sb_q.size());
      end
      done = 1'b1;
      summary();
      $finish;
   end

endmodule